// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block holds the interrupt enable register for one UART channel and tells the CPU which interrupt is pending. It has four sources. Receiver line status, transmit holding register empty and modem status change arrive as events and are held in sticky pending flags. Received data ready is a level that follows the receive holding register full flag. Each source is gated by its own enable bit. The highest-priority source that is enabled is encoded into a four-bit identifier, and an interrupt line is raised while any enabled source is pending.

The CPU reaches the block through a small register port with two addresses: the enable register and the status (identifier) register. A status read acknowledges only the source it reports. If a lower source is also pending, the next read returns it. The serial datapath, the baud generator and the line and modem status registers are outside this block. Their effects reach it as input pulses and levels.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the status register reads 0x01 and `irq` is low.
- R2: Enable register bit 0 enables received data ready, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. Bits 7:4 ignore writes and always read 0.
- R3: A source whose enable bit is 0 is never reported. When no enabled source is pending, the status register reads 0x01.
- R4: Line status has the highest priority and is reported as status 0x06.
- R5: Received data ready has the second priority and is reported as 0x04. It follows `rx_full` directly, is not cleared by a status read, and disappears when `rx_full` falls.
- R6: Transmit empty has the third priority and is reported as 0x02. It becomes pending on a rising edge of `tx_empty`.
- R7: Modem status has the lowest priority and is reported as 0x00.
- R8: A status read clears only the sticky source it reports, and that clear takes effect after the read cycle. A following read reports the next lower pending source.
- R9: A new event that arrives in the same cycle as the status read that clears its source stays pending.
- R10: `irq` is high exactly when some enabled source is pending, which is when status bit 0 is 0.
- R11: Events latch their pending flags even while disabled. Setting the enable bit later reports them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a status read acknowledges |
| addr | input | 1 | 0 selects the enable register, 1 selects the status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| line_evt | input | 1 | One-cycle pulse: receiver line status event |
| rx_full | input | 1 | Level: receive holding register full |
| tx_empty | input | 1 | Level: transmit holding register empty |
| modem_evt | input | 1 | One-cycle pulse: modem status change |
| irq | output | 1 | Interrupt request, active high |

## Verification
A lost or stuck sticky flag shows up at the first status read after the event. That read returns the wrong identifier, or `irq` disagrees with it in the same cycle. A clear that hits the wrong source shows up one read later, when the next lower level is missing or a level repeats. An enable bit that is mapped to the wrong source shows up as soon as one source is enabled alone, because its identifier then appears or fails to appear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  // Index is the priority rank: 0 is the highest.
  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_RXRDY = 2'd1,
    SRC_TXE   = 2'd2,
    SRC_MODEM = 2'd3
  } irq_src_e;

  localparam logic [3:0] CODE_IDLE = 4'b0001;

  function automatic logic [3:0] src_code(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    src_code = 4'b0110;
      2'd1:    src_code = 4'b0100;
      2'd2:    src_code = 4'b0010;
      default: src_code = 4'b0000;
    endcase
  endfunction

  // Reorder the enable bits (rx, tx, line, modem) into priority rank order.
  function automatic logic [NUM_SRC-1:0] en_by_rank(input logic [3:0] ier);
    en_by_rank = {ier[3], ier[1], ier[0], ier[2]};
  endfunction

  // A source is sticky unless it follows a level.
  function automatic bit is_sticky(input int idx);
    is_sticky = (idx != int'(SRC_RXRDY));
  endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   ier
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ier <= '0;
    else if (wr) ier <= wdata[EN_W-1:0];
  end
endmodule

// File: rtl/uart_irq_sticky_bit.sv
module uart_irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]         req,
  output logic                 valid,
  output logic [$clog2(N)-1:0] sel,
  output logic [3:0]           code
);
  always_comb begin
    valid = 1'b0;
    sel   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        sel   = i[$clog2(N)-1:0];
      end
    end
    code = valid ? src_code(sel) : CODE_IDLE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              line_evt,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              modem_evt,
  output logic              irq
);
  localparam logic ADDR_IER  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  logic [EN_W-1:0]    ier;
  logic               tx_prev_q;
  logic               tx_rise;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] masked;
  logic               stat_rd;
  logic               any_pend;
  logic [SEL_W-1:0]   sel;
  logic [3:0]         stat_code;

  uart_irq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && addr == ADDR_IER),
    .wdata(wdata), .ier(ier)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_prev_q <= 1'b0;
    else        tx_prev_q <= tx_empty;
  end

  assign tx_rise = tx_empty && !tx_prev_q;
  assign stat_rd = rd_en && addr == ADDR_STAT;
  assign set_vec = {modem_evt, tx_rise, 1'b0, line_evt};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign clr_vec[i] = stat_rd && any_pend && sel == i[SEL_W-1:0];
    if (is_sticky(i)) begin : g_sticky
      uart_irq_sticky_bit u_bit (
        .clk(clk), .rst_n(rst_n), .set(set_vec[i]), .clr(clr_vec[i]),
        .q(pend_vec[i])
      );
    end else begin : g_level
      assign pend_vec[i] = rx_full;
    end
  end

  assign masked = pend_vec & en_by_rank(ier);

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .req(masked), .valid(any_pend), .sel(sel), .code(stat_code)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_IER) rdata[EN_W-1:0] = ier;
    else                  rdata[3:0]      = stat_code;
  end

  assign irq = any_pend;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       line_evt,
  input logic       rx_full,
  input logic [3:0] ier,
  input logic [3:0] pend_vec,
  input logic [3:0] stat_code
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_code != 4'b0001)); // R10
  AST_RX_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && ier[0]) |-> irq); // R5
  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec[0] && ier[2]) |-> stat_code == 4'b0110); // R4
  AST_CLEAR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && stat_code == 4'b0110 && !line_evt) |=> !pend_vec[0]); // R8
  AST_KEEP_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && line_evt) |=> pend_vec[0]); // R9
  AST_IER_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> rdata[7:4] == 4'h0); // R2
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |-> !irq); // R3
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .line_evt(line_evt), .rx_full(rx_full), .ier(ier),
  .pend_vec(pend_vec), .stat_code(stat_code)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic line_evt = 1'b0, rx_full = 1'b0, tx_empty = 1'b0, modem_evt = 1'b0;
  logic irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .line_evt(line_evt), .rx_full(rx_full),
    .tx_empty(tx_empty), .modem_evt(modem_evt), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write_ier(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_ier(input string req, input logic [7:0] exp);
    @(negedge clk); addr = 1'b0; rd_en = 1'b1; #1;
    check(req, rdata, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Status read: checks the identifier and irq in the read cycle.
  task automatic read_stat(input string req, input logic [7:0] exp, input logic same_line = 1'b0);
    @(negedge clk); addr = 1'b1; rd_en = 1'b1; line_evt = same_line; #1;
    check(req, rdata, exp);
    check("R10", {7'b0, irq}, {7'b0, exp != 8'h01});
    @(negedge clk); rd_en = 1'b0; line_evt = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_evt = 1'b1; @(negedge clk); line_evt = 1'b0;
  endtask
  task automatic pulse_modem();
    @(negedge clk); modem_evt = 1'b1; @(negedge clk); modem_evt = 1'b0;
  endtask
  task automatic raise_tx();
    @(negedge clk); tx_empty = 1'b1; @(negedge clk); tx_empty = 1'b0;
  endtask

  task automatic t_reset();
    read_ier("R1", 8'h00);
    read_stat("R1", 8'h01);
  endtask

  task automatic t_enable_map();
    write_ier(8'hFF);
    read_ier("R2", 8'h0F);
    write_ier(8'h05);
    read_ier("R2", 8'h05);
    write_ier(8'h00);
  endtask

  task automatic t_masked_then_enable();
    pulse_line();
    pulse_modem();
    read_stat("R3", 8'h01);
    write_ier(8'h0F);
    read_stat("R11", 8'h06);
    read_stat("R8", 8'h00);
    read_stat("R8", 8'h01);
  endtask

  task automatic t_rx_only_enabled();
    write_ier(8'h01);
    pulse_line();
    read_stat("R3", 8'h01);
    @(negedge clk); rx_full = 1'b1;
    read_stat("R5", 8'h04);
    @(negedge clk); rx_full = 1'b0;
    write_ier(8'h0F);
    read_stat("R4", 8'h06);
    read_stat("R3", 8'h01);
  endtask

  task automatic t_priority_chain();
    write_ier(8'h0F);
    @(negedge clk); rx_full = 1'b1;
    raise_tx();
    pulse_modem();
    pulse_line();
    read_stat("R4", 8'h06);
    read_stat("R5", 8'h04);
    read_stat("R5", 8'h04);
    @(negedge clk); rx_full = 1'b0;
    read_stat("R6", 8'h02);
    read_stat("R7", 8'h00);
    read_stat("R8", 8'h01);
  endtask

  task automatic t_same_cycle();
    write_ier(8'h0F);
    pulse_line();
    read_stat("R9", 8'h06, 1'b1);
    read_stat("R9", 8'h06);
    read_stat("R8", 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", {7'b0, irq}, 8'h00);
    t_reset();
    t_enable_map();
    t_masked_then_enable();
    t_rx_only_enabled();
    t_priority_chain();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule